// File: doc/BRIEF.md
# Programmable Interrupt Event Router

The block takes four peripheral event lines and steers each one onto one of twelve CPU interrupt lines, named interrupts 4 to 15. Each event has a 4-bit destination code held in a configuration register. Any number of events may share one destination, and each interrupt line has its own enable bit. A sticky status flag per event captures a rising edge on that event line. Software clears the flag by writing a one to its bit.

An interrupt line is a level. It is high while at least one flag routed to it is set and the line's enable bit is on. Configuration goes through a synchronous register port. Writes take effect at the clock edge where the write is presented. Read data is registered and appears one cycle after the address.

Top module: `irq_event_router`

## Requirements
- R1: After reset, every irq_out bit is 0, the route register (address 0) reads 0x0000FFFF, the enable register (address 1) reads 0 and the flag register (address 2) reads 0.
- R2: Event e takes its destination code from route register bits [4e+3:4e]. A code c from 0 to 11 drives irq_out bit c, which is CPU interrupt 4+c.
- R3: A destination code from 12 to 15 leaves the event unrouted. Its flag is still set and visible at address 2, but no irq_out bit goes high for it.
- R4: irq_out bit k is forced to 0 while enable bit k (address 1, bit k) is 0. Setting the enable bit while a routed flag is pending drives the line high.
- R5: Several events may share a destination. The line stays high until every flag routed to it has been cleared.
- R6: A flag is set only on a 0-to-1 transition of its event input. An input held high does not set the flag again after it is cleared.
- R7: Writing address 2 clears flag e when bit e of the write data is 1. Flags whose write bit is 0 are unchanged.
- R8: If a rising edge and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: A rising edge seen at a clock edge, or a register write presented at a clock edge, is reflected in irq_out just after that same edge.
- R10: reg_rdata shows the register selected by reg_addr one cycle after the address is presented. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 4 | Peripheral event lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 route, 1 enable, 2 flags, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | 12 | Interrupt lines; bit k is CPU interrupt 4+k |

## Verification
Every result has a latency of one clock. A flag change, an irq_out change or a new reg_rdata value appears just after the first rising edge that sees the cause. The bench changes its inputs at the falling edge. It advances a behavioural model at the rising edge and compares irq_out and reg_rdata with that model at the next falling edge. So each clock is checked exactly in the cycle its result is due. Scenario checks on exact values at the same sample points cover the edge cases: same-cycle set and clear, held inputs, and unrouted codes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int NUM_OUT = 12,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_EVT*SEL_W-1:0] route_d_o,
    output logic [NUM_EVT*SEL_W-1:0] route_q_o,
    output logic [NUM_OUT-1:0]       enable_d_o,
    output logic [NUM_OUT-1:0]       enable_q_o
);
    localparam int RW = NUM_EVT * SEL_W;

    typedef struct packed {
        logic [RW-1:0]      route;
        logic [NUM_OUT-1:0] enable;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == ADDR_ROUTE)  cfg_d.route  = wdata[RW-1:0];
        if (we && addr == ADDR_ENABLE) cfg_d.enable = wdata[NUM_OUT-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.route  <= '1;
            cfg_q.enable <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign route_d_o  = cfg_d.route;
    assign route_q_o  = cfg_q.route;
    assign enable_d_o = cfg_d.enable;
    assign enable_q_o = cfg_q.enable;

    // R4
    enable_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_q.enable) |-> $past(we && addr == ADDR_ENABLE));
endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_i,
    output logic [NUM_EVT-1:0] flag_d_o,
    output logic [NUM_EVT-1:0] flag_q_o
);
    typedef struct packed {
        logic [NUM_EVT-1:0] prev;
        logic [NUM_EVT-1:0] flag;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] flag_nxt;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        assign rise[e]     = evt_i[e] & ~lat_q.prev[e];
        assign flag_nxt[e] = rise[e] | (lat_q.flag[e] & ~clr_i[e]);
    end

    always_comb begin
        lat_d      = lat_q;
        lat_d.prev = evt_i;
        lat_d.flag = flag_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign flag_d_o = lat_d.flag;
    assign flag_q_o = lat_q.flag;

    // R8
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((lat_q.flag & $past(rise)) == $past(rise)));

    // R7
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~rise)) |=> ((lat_q.flag & $past(clr_i & ~rise)) == '0));

    // R6
    flag_set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_q.flag & ~$past(lat_q.flag)) & ~$past(evt_i)) == '0);
endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine #(
    parameter int NUM_EVT = 4,
    parameter int NUM_OUT = 12,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_EVT-1:0]       flag_i,
    input  logic [NUM_EVT*SEL_W-1:0] route_i,
    input  logic [NUM_OUT-1:0]       enable_i,
    output logic [NUM_OUT-1:0]       irq_o
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int e = 0; e < NUM_EVT; e++) begin
                if (flag_i[e] && route_i[e*SEL_W +: SEL_W] == SEL_W'(k)) hit = 1'b1;
            end
        end
        assign irq_o[k] = hit & enable_i[k];
    end
endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
    import irq_router_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int NUM_OUT = 12,
    parameter int SEL_W   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_OUT-1:0]  irq_out
);
    localparam int RW = NUM_EVT * SEL_W;

    typedef struct packed {
        logic [DATA_W-1:0]  rdata;
        logic [NUM_OUT-1:0] irq;
    } top_t;

    top_t top_d, top_q;

    logic [RW-1:0]      route_d, route_q;
    logic [NUM_OUT-1:0] enable_d, enable_q;
    logic [NUM_EVT-1:0] flag_d, flag_q, clr;
    logic [NUM_OUT-1:0] irq_nxt;

    assign clr = (reg_we && reg_addr == ADDR_FLAGS) ? reg_wdata[NUM_EVT-1:0] : '0;

    irq_cfg_regs #(.NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .DATA_W(DATA_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .route_d_o(route_d), .route_q_o(route_q),
        .enable_d_o(enable_d), .enable_q_o(enable_q)
    );

    irq_event_latch #(.NUM_EVT(NUM_EVT)) lat_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_in), .clr_i(clr),
        .flag_d_o(flag_d), .flag_q_o(flag_q)
    );

    irq_route_combine #(.NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) comb_i (
        .flag_i(flag_d), .route_i(route_d), .enable_i(enable_d), .irq_o(irq_nxt)
    );

    always_comb begin
        top_d     = top_q;
        top_d.irq = irq_nxt;
        case (reg_addr)
            ADDR_ROUTE:  top_d.rdata = DATA_W'(route_q);
            ADDR_ENABLE: top_d.rdata = DATA_W'(enable_q);
            ADDR_FLAGS:  top_d.rdata = DATA_W'(flag_q);
            default:     top_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;
    assign irq_out   = top_q.irq;

    // R4
    masked_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~enable_q) == '0);

    // R5
    no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q == '0) |-> (irq_out == '0));

    // R10
    unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |=> (reg_rdata == '0));
endmodule

// File: tb/irq_event_router_tb_top.sv
module irq_event_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt = '0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [11:0] irq;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    int m_route = 32'hFFFF, m_en = 0, m_flag = 0, m_prev = 0, m_irq = 0, m_rd = 0;

    always #10 clk = ~clk;

    irq_event_router dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
    );

    task automatic check(string t, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    task automatic model_step();
        int rise, clr, sel;
        case (addr)
            2'd0: m_rd = m_route;
            2'd1: m_rd = m_en;
            2'd2: m_rd = m_flag;
            default: m_rd = 0;
        endcase
        rise   = int'(evt) & ~m_prev & 4'hF;
        m_prev = int'(evt);
        clr    = (we && addr == 2'd2) ? int'(wdata[3:0]) : 0;
        m_flag = ((m_flag & ~clr) | rise) & 4'hF;
        if (we && addr == 2'd0) m_route = int'(wdata[15:0]);
        if (we && addr == 2'd1) m_en = int'(wdata[11:0]);
        m_irq = 0;
        for (int e = 0; e < 4; e++) begin
            sel = (m_route >> (4 * e)) & 4'hF;
            if (((m_flag >> e) & 1) == 1 && sel < 12) m_irq |= (1 << sel);
        end
        m_irq &= m_en;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check({tag, " irq"}, int'(irq), m_irq);
        check({tag, " rdata"}, int'(rdata), m_rd);
        we = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd(logic [1:0] a);
        addr = a;
        tick();
    endtask

    task automatic pulse(logic [3:0] v);
        evt = v; tick();
        evt = '0; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        check("R1 irq after reset", int'(irq), 0);
        rd(2'd0); check("R1 route reset", int'(rdata), 32'hFFFF);
        rd(2'd1); check("R1 enable reset", int'(rdata), 0);
        rd(2'd2); check("R1 flags reset", int'(rdata), 0);

        tag = "R2";
        wr(2'd1, 32'hFFF);
        wr(2'd0, 32'hFFF5);
        tag = "R9";
        evt = 4'b0001; tick();
        check("R9 irq one edge after rise", int'(irq), 1 << 5);
        evt = '0; tick();
        tag = "R2";
        check("R2 code 5 to bit 5", int'(irq), 1 << 5);
        wr(2'd2, 32'h1);
        check("R7 cleared line drops", int'(irq), 0);
        wr(2'd0, 32'hFB0F);
        pulse(4'b0110);
        check("R2 codes 0 and 11", int'(irq), 12'h801);
        wr(2'd2, 32'hF);

        tag = "R3";
        wr(2'd0, 32'hC005);
        pulse(4'b1000);
        check("R3 unrouted no irq", int'(irq), 0);
        rd(2'd2); check("R3 flag still latched", int'(rdata), 4'h8);
        wr(2'd2, 32'h8);

        tag = "R4";
        wr(2'd1, 32'hFDF);
        pulse(4'b0001);
        check("R4 masked line low", int'(irq), 0);
        tag = "R9";
        wr(2'd1, 32'hFFF);
        check("R9 R4 enable shows pending", int'(irq), 1 << 5);
        wr(2'd2, 32'hF);

        tag = "R5";
        wr(2'd0, 32'hFF77);
        pulse(4'b0011);
        check("R5 merged line high", int'(irq), 1 << 7);
        wr(2'd2, 32'h1);
        check("R5 one source left", int'(irq), 1 << 7);
        wr(2'd2, 32'h2);
        check("R5 all cleared", int'(irq), 0);

        tag = "R6";
        wr(2'd0, 32'hF3FF);
        evt = 4'b0100; tick(); tick();
        check("R6 held sets", int'(irq), 1 << 3);
        wr(2'd2, 32'h4); tick(); tick();
        check("R6 held no reset", int'(irq), 0);
        evt = '0; tick();

        tag = "R7";
        wr(2'd0, 32'h3210);
        pulse(4'b1111);
        wr(2'd2, 32'h5);
        rd(2'd2); check("R7 only ones clear", int'(rdata), 4'hA);
        check("R7 lines left", int'(irq), 12'hA);
        wr(2'd2, 32'hF);

        tag = "R8";
        evt = 4'b0010; we = 1'b1; addr = 2'd2; wdata = 32'h2; tick();
        evt = '0;
        rd(2'd2); check("R8 set wins", int'(rdata), 4'h2);
        check("R8 line high", int'(irq), 1 << 1);

        tag = "R10";
        rd(2'd3); check("R10 addr3 zero", int'(rdata), 0);
        rd(2'd1); check("R10 enable readback", int'(rdata), 32'hFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule